// File: doc/BRIEF.md
# Dual-Stream Result Delay Checker

This block sits behind two copies of one instruction stream running side by side. The copy that runs ahead, the leading stream, hands each finished result to the block together with a sequence tag. The block parks these in a small first-in first-out delay buffer. The copy that runs behind, the trailing stream, then offers its own result for the same tag. The block takes the oldest parked entry and compares tag and value with the trailing result. Only results that agree leave on the commit port, so a fault in the trailing copy is caught before anything it produced becomes architectural. A fault in the leading copy is only seen once its entry reaches the head of the buffer, which happens later.

Any disagreement, in the tag or in the value, counts as an error. The block then emits a one-cycle error pulse and throws away every parked entry. It holds both streams stalled with its rollback output high until the surrounding logic has restored the last committed trailing state and answers with a restart pulse. A new disagreement may follow straight after a restart, so rollbacks can come back to back. Two saturating counters keep a tally of commits and of detected errors.

Top module: `dual_stream_checker`

## Requirements
- R1: After reset, lead_ready is 1, trail_ready is 0, commit_valid, error_pulse and rollback are 0, and both counters read 0.
- R2: Every trailing result is compared with the oldest buffered leading entry, so commits come out in the order the leading stream pushed them.
- R3: lead_ready is 0 whenever DEPTH entries are buffered, and no accepted entry is lost or overwritten.
- R4: trail_ready is 0 whenever the buffer is empty.
- R5: When an accepted trailing result has the same tag and the same value as the head entry, commit_valid is 1 in the next cycle with that tag and value on commit_seq and commit_data, and commit_count rises by one.
- R6: When an accepted trailing result has a different value from the head entry, in the next cycle error_pulse is 1 for one cycle, rollback is 1, err_count rises by one, and nothing commits.
- R7: A tag difference with an identical value is an error with the same effects as in R6.
- R8: While rollback is 1, lead_ready and trail_ready are both 0 and restart is the only input with any effect. The cycle after restart is sampled high, rollback is 0 and the buffer is empty.
- R9: An error flushes the buffer, and a leading entry accepted in the same cycle as the error is discarded as well.
- R10: Both counters stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| lead_valid | input | 1 | Leading stream offers a result |
| lead_seq | input | SEQ_W | Tag of the leading result |
| lead_data | input | DATA_W | Value of the leading result |
| lead_ready | output | 1 | Buffer accepts a leading result this cycle |
| trail_valid | input | 1 | Trailing stream offers a result |
| trail_seq | input | SEQ_W | Tag of the trailing result |
| trail_data | input | DATA_W | Value of the trailing result |
| trail_ready | output | 1 | Trailing result is compared this cycle |
| restart | input | 1 | Recovery finished; leave rollback |
| commit_valid | output | 1 | A checked result commits |
| commit_seq | output | SEQ_W | Tag of the committed result |
| commit_data | output | DATA_W | Value of the committed result |
| error_pulse | output | 1 | One-cycle pulse on a detected disagreement |
| rollback | output | 1 | Streams held; restore last committed trailing state |
| commit_count | output | CNT_W | Saturating number of commits |
| err_count | output | CNT_W | Saturating number of errors |

## Verification
The collision that matters here is a leading push landing in the same cycle as a trailing compare. When the compare agrees, the push and the pop together must leave the fill level unchanged. When it disagrees, the flush must beat the push. The bench provokes this directly: it pushes into a buffer that already holds an entry while a corrupted trailing result arrives. It also lets the random phase drive both streams at once with injected corruptions, and after each restart it checks that trail_ready stays low, which shows the buffer came back empty.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } dsc_state_e;
endpackage

// File: rtl/dsc_delay_fifo.sv
module dsc_delay_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_step(wr_ptr);
      if (pop)  rd_ptr <= ptr_step(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dsc_compare.sv
module dsc_compare #(
  parameter int SEQ_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic [SEQ_W-1:0]  ref_seq,
  input  logic [DATA_W-1:0] ref_data,
  input  logic [SEQ_W-1:0]  chk_seq,
  input  logic [DATA_W-1:0] chk_data,
  output logic              seq_ok,
  output logic              data_ok
);
  function automatic logic same_bits_seq(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    return ~|(a ^ b);
  endfunction

  function automatic logic same_bits_data(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return ~|(a ^ b);
  endfunction

  assign seq_ok  = same_bits_seq(ref_seq, chk_seq);
  assign data_ok = same_bits_data(ref_data, chk_data);
endmodule

// File: rtl/dsc_sat_counter.sv
module dsc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (inc) value <= sat_inc(value);
  end
endmodule

// File: rtl/dual_stream_checker.sv
module dual_stream_checker #(
  parameter int SEQ_W  = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_valid,
  input  logic [SEQ_W-1:0]  lead_seq,
  input  logic [DATA_W-1:0] lead_data,
  output logic              lead_ready,
  input  logic              trail_valid,
  input  logic [SEQ_W-1:0]  trail_seq,
  input  logic [DATA_W-1:0] trail_data,
  output logic              trail_ready,
  input  logic              restart,
  output logic              commit_valid,
  output logic [SEQ_W-1:0]  commit_seq,
  output logic [DATA_W-1:0] commit_data,
  output logic              error_pulse,
  output logic              rollback,
  output logic [CNT_W-1:0]  commit_count,
  output logic [CNT_W-1:0]  err_count
);
  import dsc_pkg::*;

  localparam int ENT_W = SEQ_W + DATA_W;
  localparam int CW    = $clog2(DEPTH + 1);

  dsc_state_e        state_q;
  logic [ENT_W-1:0]  head_ent;
  logic [SEQ_W-1:0]  head_seq;
  logic [DATA_W-1:0] head_data;
  logic [CW-1:0]     buf_count;
  logic              buf_full, buf_empty;
  logic              seq_ok, data_ok;

  // named internal events
  logic running, push_evt, pop_evt, match_evt, miss_evt;

  assign running     = (state_q == ST_RUN);
  assign lead_ready  = running && !buf_full;
  assign trail_ready = running && !buf_empty;
  assign push_evt    = lead_valid && lead_ready;
  assign pop_evt     = trail_valid && trail_ready;
  assign match_evt   = pop_evt && seq_ok && data_ok;
  assign miss_evt    = pop_evt && !(seq_ok && data_ok);
  assign {head_seq, head_data} = head_ent;
  assign rollback    = (state_q == ST_HOLD);

  dsc_delay_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (miss_evt),
    .push  (push_evt),
    .din   ({lead_seq, lead_data}),
    .pop   (match_evt),
    .dout  (head_ent),
    .count (buf_count),
    .full  (buf_full),
    .empty (buf_empty)
  );

  dsc_compare #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_cmp (
    .ref_seq  (head_seq),
    .ref_data (head_data),
    .chk_seq  (trail_seq),
    .chk_data (trail_data),
    .seq_ok   (seq_ok),
    .data_ok  (data_ok)
  );

  dsc_sat_counter #(.W(CNT_W)) u_commit_cnt (
    .clk (clk), .rst_n (rst_n), .inc (match_evt), .value (commit_count)
  );

  dsc_sat_counter #(.W(CNT_W)) u_err_cnt (
    .clk (clk), .rst_n (rst_n), .inc (miss_evt), .value (err_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:  if (miss_evt) state_q <= ST_HOLD;
        ST_HOLD: if (restart)  state_q <= ST_RUN;
        default: state_q <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_valid <= 1'b0;
      commit_seq   <= '0;
      commit_data  <= '0;
      error_pulse  <= 1'b0;
    end else begin
      commit_valid <= match_evt;
      error_pulse  <= miss_evt;
      if (match_evt) begin
        commit_seq  <= head_seq;
        commit_data <= head_data;
      end
    end
  end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lead_ready,
  input logic          trail_ready,
  input logic          push_evt,
  input logic          match_evt,
  input logic          miss_evt,
  input logic          commit_valid,
  input logic          error_pulse,
  input logic          rollback,
  input logic [CW-1:0] buf_count
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> (buf_count < CW'(DEPTH)));

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count <= CW'(DEPTH));

  assert_pop_has_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trail_ready |-> (buf_count != '0));

  assert_commit_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (commit_valid && !error_pulse));

  assert_miss_rolls_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (error_pulse && rollback && !commit_valid));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (buf_count == '0));

  assert_hold_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |-> (!lead_ready && !trail_ready));
endmodule

bind dual_stream_checker dsc_checker #(.DEPTH(DEPTH)) u_dsc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .lead_ready   (lead_ready),
  .trail_ready  (trail_ready),
  .push_evt     (push_evt),
  .match_evt    (match_evt),
  .miss_evt     (miss_evt),
  .commit_valid (commit_valid),
  .error_pulse  (error_pulse),
  .rollback     (rollback),
  .buf_count    (buf_count)
);

// File: tb/test_dual_stream_checker.sv
module test_dual_stream_checker;
  localparam int SW = 8;
  localparam int DW = 16;
  localparam int DP = 4;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_valid = 0, trail_valid = 0, restart = 0;
  logic [SW-1:0] lead_seq = '0, trail_seq = '0;
  logic [DW-1:0] lead_data = '0, trail_data = '0;
  logic lead_ready, trail_ready, commit_valid, error_pulse, rollback;
  logic [SW-1:0] commit_seq;
  logic [DW-1:0] commit_data;
  logic [CW-1:0] commit_count, err_count;

  always #2 clk = ~clk;

  dual_stream_checker #(.SEQ_W(SW), .DATA_W(DW), .DEPTH(DP), .CNT_W(CW)) i_dual_stream_checker (
    .clk(clk), .rst_n(rst_n),
    .lead_valid(lead_valid), .lead_seq(lead_seq), .lead_data(lead_data), .lead_ready(lead_ready),
    .trail_valid(trail_valid), .trail_seq(trail_seq), .trail_data(trail_data), .trail_ready(trail_ready),
    .restart(restart),
    .commit_valid(commit_valid), .commit_seq(commit_seq), .commit_data(commit_data),
    .error_pulse(error_pulse), .rollback(rollback),
    .commit_count(commit_count), .err_count(err_count)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [SW+DW-1:0] q[$];
  bit m_hold = 0;
  logic [CW-1:0] m_cc = '0, m_ec = '0;
  bit x_cv = 0, x_err = 0;
  logic [SW-1:0] x_cs = '0;
  logic [DW-1:0] x_cd = '0;
  logic [SW-1:0] lead_ctr = '0;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    if (v == CMAX) return v;
    return v + 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle: check, drive, predict
  task automatic cycle(input bit lv, input bit tv, input logic [SW-1:0] ts,
                       input logic [DW-1:0] td, input bit rs);
    bit exp_lr, exp_tr, push, pop;
    logic [SW+DW-1:0] head;
    logic [DW-1:0] ld;
    @(negedge clk);
    chk("R5 commit_valid", 32'(commit_valid), 32'(x_cv));
    if (x_cv) begin
      chk("R2 commit_seq", 32'(commit_seq), 32'(x_cs));
      chk("R2 commit_data", 32'(commit_data), 32'(x_cd));
    end
    chk("R6 error_pulse", 32'(error_pulse), 32'(x_err));
    chk("R8 rollback", 32'(rollback), 32'(m_hold));
    chk("R10 commit_count", 32'(commit_count), 32'(m_cc));
    chk("R10 err_count", 32'(err_count), 32'(m_ec));
    exp_lr = !m_hold && (q.size() < DP);
    exp_tr = !m_hold && (q.size() > 0);
    chk("R3 lead_ready", 32'(lead_ready), 32'(exp_lr));
    chk("R4 trail_ready", 32'(trail_ready), 32'(exp_tr));
    ld = DW'($urandom);
    lead_valid = lv; lead_seq = lead_ctr; lead_data = ld;
    trail_valid = tv; trail_seq = ts; trail_data = td;
    restart = rs;
    push = lv && exp_lr;
    pop  = tv && exp_tr;
    x_cv = 0; x_err = 0;
    if (m_hold) begin
      if (rs) m_hold = 0;
    end else begin
      if (pop) begin
        head = q[0];
        if (head == {ts, td}) begin
          x_cv = 1; {x_cs, x_cd} = head;
          m_cc = bump(m_cc);
          void'(q.pop_front());
          if (push) q.push_back({lead_ctr, ld});
        end else begin
          x_err = 1; m_ec = bump(m_ec);
          m_hold = 1; q.delete();
        end
      end else if (push) begin
        q.push_back({lead_ctr, ld});
      end
      if (push) lead_ctr++;
    end
    @(posedge clk); #1;
  endtask

  // trailing values taken from the model's oldest entry
  function automatic logic [SW+DW-1:0] head_or_zero();
    if (q.size() > 0) return q[0];
    return '0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SW+DW-1:0] h;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 lead_ready", 32'(lead_ready), 1);
    chk("R1 trail_ready", 32'(trail_ready), 0);
    chk("R1 commit_valid", 32'(commit_valid), 0);
    chk("R1 rollback", 32'(rollback), 0);
    chk("R1 counters", 32'({commit_count, err_count}), 0);

    // R3: fill to depth with trailing idle
    for (int i = 0; i < DP + 2; i++) cycle(1, 0, '0, '0, 0);
    chk("R3 full stalls lead", 32'(lead_ready), 0);
    // R2: drain in order
    for (int i = 0; i < DP; i++) begin
      h = head_or_zero();
      cycle(0, 1, h[SW+DW-1:DW], h[DW-1:0], 0);
    end
    cycle(0, 0, '0, '0, 0);
    // R4: empty, trailing offer ignored
    chk("R4 empty", 32'(trail_ready), 0);
    cycle(0, 1, 8'h55, 16'h1234, 0);
    chk("R4 no commit from empty", 32'(commit_valid), 0);
    // R7: tag differs, value equal
    cycle(1, 0, '0, '0, 0);
    h = head_or_zero();
    cycle(0, 1, h[SW+DW-1:DW] ^ 8'h01, h[DW-1:0], 0);
    chk("R7 tag error", 32'(error_pulse), 1);
    chk("R7 rollback", 32'(rollback), 1);
    cycle(1, 0, '0, '0, 0);
    chk("R8 push ignored in hold", 32'(lead_ready), 0);
    cycle(0, 0, '0, '0, 1);
    // R9: push collides with a failing compare, then back-to-back rollback
    cycle(1, 0, '0, '0, 0);
    h = head_or_zero();
    cycle(1, 1, h[SW+DW-1:DW], h[DW-1:0] ^ 16'h8000, 0);
    cycle(0, 0, '0, '0, 1);
    chk("R9 flushed after restart", 32'(trail_ready), 0);
    chk("R8 running again", 32'(lead_ready), 1);
    cycle(1, 0, '0, '0, 0);
    h = head_or_zero();
    cycle(0, 1, h[SW+DW-1:DW], ~h[DW-1:0], 0);
    chk("R6 back-to-back error", 32'(error_pulse), 1);
    cycle(0, 0, '0, '0, 1);

    // random mix, counters reach saturation (R10)
    for (int i = 0; i < 3000; i++) begin
      logic [SW-1:0] ts;
      logic [DW-1:0] td;
      int r;
      h = head_or_zero();
      ts = h[SW+DW-1:DW]; td = h[DW-1:0];
      r = $urandom_range(99);
      if (r < 6) td = td ^ DW'(1 << $urandom_range(DW-1));
      else if (r < 9) ts = ts + 1'b1;
      cycle($urandom_range(99) < 60, $urandom_range(99) < 55, ts, td,
            $urandom_range(99) < 30);
    end
    cycle(0, 0, '0, '0, 1);
    chk("R10 commit saturates", 32'(commit_count), 32'(CMAX));
    chk("R10 err saturates", 32'(err_count), 32'(CMAX));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule